// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Aggregator

This block gathers ten completion and error events from a DMA bridge into one 32-bit control and status register, and turns them into three interrupt request lines. Two events belong to a USB DMA path: transfer complete and address error. The other eight come from two audio channels. Each channel has a playback and a record direction, and each direction reports when half of its buffer is done and when all of it is done.

Each event sets a sticky status bit. Software clears that bit by writing zero to it. Each event also has an enable bit that masks it from the interrupt lines. A masked event still records its status, so software can poll for it. The lines are grouped unevenly:
- Line 0 serves the USB address error alone.
- Line 1 serves USB transfer complete and the four all-done events.
- Line 2 serves the four half-done events.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every status and enable bit is 0, `rd_data` reads 0 and all three `irq` lines are low.
- R2: A high `evt[n]` in a cycle sets status bit n at the next clock edge, whether its enable is set or not. Status bit positions are n for n = 0 and 1, and n+14 for n = 2 to 9 (bits 16 to 23).
- R3: A write with 0 at a status position clears that status bit. A write with 1 there leaves it unchanged.
- R4: Each enable bit sits 8 positions above its status bit: bits 8 and 9 for events 0 and 1, and bits 24 to 31 for events 2 to 9. Enable bits are plain read/write bits that take the written value.
- R5: Register bits 2 to 7 and 10 to 15 always read 0, even after 1s are written to them.
- R6: If `evt[n]` is high in the same cycle as a write of 0 to status bit n, the bit ends set.
- R7: `irq[0]` responds only to event 1.
- R8: `irq[1]` responds to events 0, 2, 4, 6 and 8.
- R9: `irq[2]` responds to events 3, 5, 7 and 9.
- R10: Each line is a registered level. It is high one cycle after any of its events has both its status bit and its enable bit at 1, and it stays high while that holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 10 | One-cycle event pulses, bit n is event n |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| irq | output | 3 | Interrupt request levels |

## Verification
The main sweep drives each of the ten events on its own, once masked and once enabled. This shows that the status bit is set in its own position, and that exactly one line rises, and only when the event is enabled. A second sweep covers all 1024 combinations of simultaneous events with every enable set, which exposes any event assigned to the wrong line or any line that mixes in a neighbour. Directed writes then separate the clear-on-zero case from keep-on-one, check that a clear loses against a simultaneous event, and check that the reserved bits stay zero.

// File: rtl/evtagg_pkg.sv
package evtagg_pkg;
  localparam int EVT_N  = 10;
  localparam int REG_W  = 32;
  localparam int LINE_N = 3;
  localparam int EN_OFS = 8;

  // status bit position of event n
  function automatic int stat_pos(input int n);
    return (n < 2) ? n : n + 14;
  endfunction

  function automatic int en_pos(input int n);
    return stat_pos(n) + EN_OFS;
  endfunction

  // which interrupt line event n feeds
  function automatic int line_of(input int n);
    if (n == 1) return 0;
    if (n == 0) return 1;
    return (n % 2 == 0) ? 1 : 2;
  endfunction

  function automatic logic [EVT_N-1:0] line_mask(input int l);
    logic [EVT_N-1:0] m;
    m = '0;
    for (int i = 0; i < EVT_N; i++) m[i] = (line_of(i) == l);
    return m;
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evtagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic             wr_en,
  input  logic [EVT_N-1:0] wr_stat,
  input  logic [EVT_N-1:0] wr_enb,
  output logic [EVT_N-1:0] stat_q,
  output logic [EVT_N-1:0] en_q
);
  for (genvar g = 0; g < EVT_N; g++) begin : g_bit
    logic keep;
    assign keep = wr_en ? (stat_q[g] & wr_stat[g]) : stat_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[g] <= 1'b0;
        en_q[g]   <= 1'b0;
      end else begin
        stat_q[g] <= keep | evt[g];
        if (wr_en) en_q[g] <= wr_enb[g];
      end
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> stat_q[g]); // R2
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_stat[g] && !evt[g]) |=> !stat_q[g]); // R3
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_stat[g] && !evt[g]) |=> (stat_q[g] == $past(stat_q[g]))); // R3
    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_stat[g] && evt[g]) |=> stat_q[g]); // R6
    AST_EN_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en_q[g] == $past(wr_enb[g]))); // R4
  end
endmodule

// File: rtl/evt_line_merge.sv
module evt_line_merge
  import evtagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  stat_q,
  input  logic [EVT_N-1:0]  en_q,
  output logic [LINE_N-1:0] irq_q
);
  logic [EVT_N-1:0] pend;
  assign pend = stat_q & en_q;

  for (genvar l = 0; l < LINE_N; l++) begin : g_line
    localparam logic [EVT_N-1:0] MASK = line_mask(l);
    logic hit;
    assign hit = |(pend & MASK);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[l] <= 1'b0;
      else        irq_q[l] <= hit;
    end

    AST_LINE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & en_q & MASK)) |=> irq_q[l]); // R10
  end

  AST_LINE0_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_q[1] && en_q[1]) |=> !irq_q[0]); // R7
  AST_LINE2_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_q & en_q) & 10'b1010101000) == '0) |=> !irq_q[2]); // R9
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evtagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [LINE_N-1:0] irq
);
  logic [EVT_N-1:0] wr_stat, wr_enb, stat_q, en_q;

  for (genvar g = 0; g < EVT_N; g++) begin : g_fld
    assign wr_stat[g] = wr_data[stat_pos(g)];
    assign wr_enb[g]  = wr_data[en_pos(g)];
  end

  evt_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
    .wr_stat(wr_stat), .wr_enb(wr_enb), .stat_q(stat_q), .en_q(en_q)
  );

  evt_line_merge u_merge (
    .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .en_q(en_q), .irq_q(irq)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < EVT_N; i++) begin
      rd_data[stat_pos(i)] = stat_q[i];
      rd_data[en_pos(i)]   = en_q[i];
    end
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & 32'h0000_FCFC) == '0)); // R5
endmodule

// File: tb/sim_evt_irq_agg.sv
module sim_evt_irq_agg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] evt = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0] irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_irq_agg u0 (.clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
                  .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  function automatic int spos(int n);
    return (n <= 1) ? n : 16 + (n - 2);
  endfunction

  // pack status and enable vectors into the register image
  function automatic logic [31:0] image(logic [9:0] s, logic [9:0] e);
    logic [31:0] r = '0;
    for (int n = 0; n < 10; n++) begin
      r[spos(n)]     = s[n];
      r[spos(n) + 8] = e[n];
    end
    return r;
  endfunction

  function automatic logic [2:0] lines(logic [9:0] p);
    logic [2:0] o;
    o[0] = p[1];
    o[1] = p[0] | p[2] | p[4] | p[6] | p[8];
    o[2] = p[3] | p[5] | p[7] | p[9];
    return o;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [9:0] e, logic w, logic [31:0] d);
    evt = e; wr_en = w; wr_data = d;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reg", rd_data, 0);
    chk("R1 irq", {29'b0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single event sweep, masked and enabled (R2 R4 R7 R8 R9 R10)
    for (int n = 0; n < 10; n++) begin
      for (int m = 0; m < 2; m++) begin
        logic [9:0] en = m ? (10'b1 << n) : 10'b0;
        logic [9:0] st = 10'b1 << n;
        cyc('0, 1'b1, image('0, en));
        @(negedge clk);
        cyc(st, 1'b0, '0);
        chk("R2 latch", rd_data, image(st, en));
        chk("R10 lag", {29'b0, irq}, 0);
        @(negedge clk);
        chk(n == 1 ? "R7 line" : (n % 2 == 1 ? "R9 line" : "R8 line"),
            {29'b0, irq}, {29'b0, lines(st & en)});
        @(negedge clk);
        chk("R10 hold", {29'b0, irq}, {29'b0, lines(st & en)});
        cyc('0, 1'b1, '0);
        chk("R3 clear", rd_data, 0);
        @(negedge clk);
        chk("R10 drop", {29'b0, irq}, 0);
      end
    end

    // all event combinations with everything enabled (R7 R8 R9)
    for (int p = 0; p < 1024; p++) begin
      cyc(p[9:0], 1'b1, image('0, 10'h3FF));
      @(negedge clk);
      chk("R8 R9 combo", {rd_data, 29'b0, irq},
          {image(p[9:0], 10'h3FF), 29'b0, lines(p[9:0])});
      cyc('0, 1'b1, '0);
    end

    // write 1 keeps, write 0 clears, selectively (R3)
    cyc(10'h3FF, 1'b0, '0);
    cyc('0, 1'b1, image(10'b1010101010, 10'h0F0));
    chk("R3 mixed", rd_data, image(10'b1010101010, 10'h0F0));

    // event beats simultaneous clear (R6)
    cyc(10'b0000100001, 1'b1, image('0, '0));
    chk("R6 race", rd_data, image(10'b0000100001, '0));

    // reserved bits (R5)
    cyc('0, 1'b1, 32'hFFFF_FFFF);
    chk("R5 reserved", rd_data, image(10'b0000100001, 10'h3FF));
    cyc('0, 1'b1, 32'h0000_FCFC);
    chk("R5 only reserved", rd_data, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule